// File: doc/BRIEF.md
# DMA Destination Address and Acknowledge Unit

This unit keeps the control settings of one DMA channel and, from them, works out two things for each transfer: the next destination address and the acknowledge strobe sent to an external device. Software writes a control byte and loads a start address. A separate transfer engine reports bus cycles and completed beats. The unit advances the address by the transfer size in the chosen direction. It drives the acknowledge in the correct bus cycle, with the configured active level.

Some combinations of direction and size cannot be carried out. When one of these is written, a configuration-error flag is raised, and the address and acknowledge are frozen until a legal control byte is written. The channel index is a parameter. Channels 2 and above have no acknowledge-mode or acknowledge-level controls: those bits read as 0 and writes to them are dropped.

Control byte layout, with bit 0 as the least significant bit:
- `[1:0]` destination mode: 00 fixed, 01 increment, 10 decrement, 11 reserved.
- `[3:2]` transfer size: 00 byte, 01 word, 10 longword, 11 sixteen-byte burst.
- `[4]` acknowledge phase: 0 selects the read cycle, 1 selects the write cycle.
- `[5]` acknowledge level: 0 is active low, 1 is active high.
- `[6]` addressing: 0 is dual, 1 is single.
- `[7]` single-mode direction: 1 means data goes to the external device.

Top module: `dma_dst_ack_unit`

## Requirements
- R1: After reset, the control readback is 0, the address is 0, cfg_err is 0 and dack is 1, which is the inactive level for active low.
- R2: In increment mode (01), each xfer_done beat adds 1, 2, 4 or 16 to the address for size 00, 01, 10 or 11. The new value is visible after the clock edge that samples xfer_done.
- R3: In decrement mode (10), each beat subtracts 1, 2 or 4 for size 00, 01 or 10.
- R4: In fixed mode (00), a beat leaves the address unchanged.
- R5: cfg_err is set when a control byte with mode 11 is written, or with size 11 combined with mode 00 or 10. It is cleared by the next write of a legal byte, and otherwise keeps its value.
- R6: While cfg_err is 1, beats do not change the address and dack stays at its inactive level.
- R7: In dual mode (bit 6 = 0), bit 4 = 0 makes dack active only for a read-cycle strobe, and bit 4 = 1 only for a write-cycle strobe. dack is registered and is active in the cycle after the strobe.
- R8: In single mode, dack is active after any read or write strobe, whatever bit 4 holds.
- R9: With bit 5 = 0, the active level of dack is 0; with bit 5 = 1, it is 1. In the cycle after a cycle with no qualifying strobe, dack is at the opposite, inactive level.
- R10: In single mode with bit 7 = 1, beats leave the address unchanged whatever the mode bits hold. With bit 7 = 0, the address steps as usual.
- R11: On a channel with CHAN_ID of 2 or more, bits 5 and 4 always read back 0. The acknowledge is active low and appears in the read cycle in dual mode.
- R12: Address arithmetic wraps modulo 2^ADDR_W: incrementing past the top wraps to the bottom, and decrementing below 0 wraps to the top.
- R13: addr_we loads addr_wdata on the next edge and takes priority over a beat in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte to write |
| ctl_rdata | output | 8 | Control byte readback |
| addr_we | input | 1 | Destination address load strobe |
| addr_wdata | input | ADDR_W | Address value to load |
| rd_cyc | input | 1 | A read bus cycle of the current transfer is under way |
| wr_cyc | input | 1 | A write bus cycle of the current transfer is under way |
| xfer_done | input | 1 | One-cycle pulse marking a completed beat |
| dst_addr | output | ADDR_W | Current destination address |
| dack | output | 1 | Acknowledge strobe, with the configured level |
| cfg_err | output | 1 | Prohibited configuration flag |

## Verification
The assertions assume that control writes, address loads and bus-cycle strobes are clean, single-cycle synchronous pulses. They also assume that the control byte, which sets the acknowledge level and the error state, changes only through ctl_we, so the value sampled at one edge explains the dack and address seen after it. The stimulus drives every input on the falling clock edge and holds each strobe for exactly one cycle. It never raises rd_cyc and wr_cyc together, and it loads a new control byte only between beats, except in the one case that tests load-over-beat priority.

// File: rtl/dmau_pkg.sv
package dmau_pkg;

  typedef enum logic [1:0] {
    DM_FIXED = 2'b00,
    DM_INC   = 2'b01,
    DM_DEC   = 2'b10,
    DM_RSVD  = 2'b11
  } dmode_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_WORD  = 2'b01,
    SZ_LONG  = 2'b10,
    SZ_BURST = 2'b11
  } size_e;

  typedef struct packed {
    logic   to_dev;
    logic   single;
    logic   ack_pol;
    logic   ack_wr;
    size_e  size;
    dmode_e dmode;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // Bytes moved by one beat of the given size.
  function automatic logic [4:0] beat_bytes(size_e sz);
    case (sz)
      SZ_BYTE: beat_bytes = 5'd1;
      SZ_WORD: beat_bytes = 5'd2;
      SZ_LONG: beat_bytes = 5'd4;
      default: beat_bytes = 5'd16;
    endcase
  endfunction

  // Mode/size pairs that cannot be executed.
  function automatic logic cfg_illegal(dmode_e m, size_e sz);
    cfg_illegal = (m == DM_RSVD) || ((sz == SZ_BURST) && (m != DM_INC));
  endfunction

  // Whether a strobe set qualifies for acknowledge under a given mode.
  function automatic logic ack_wanted(logic single, logic ack_wr,
                                      logic rd, logic wr);
    if (single) ack_wanted = rd | wr;
    else        ack_wanted = ack_wr ? wr : rd;
  endfunction

endpackage

// File: rtl/dmau_ctl_regs.sv
module dmau_ctl_regs
  import dmau_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output ctl_t             ctl_q,
  output logic             cfg_err
);

  localparam bit HAS_ACK_CTL = (CHAN_ID < 2);

  ctl_t wr_ctl;
  ctl_t ctl_r;
  logic err_r;
  logic new_illegal;

  generate
    if (HAS_ACK_CTL) begin : g_full
      always_comb wr_ctl = ctl_t'(ctl_wdata);
    end else begin : g_reduced
      always_comb begin
        wr_ctl         = ctl_t'(ctl_wdata);
        wr_ctl.ack_pol = 1'b0;
        wr_ctl.ack_wr  = 1'b0;
      end
    end
  endgenerate

  assign new_illegal = cfg_illegal(wr_ctl.dmode, wr_ctl.size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_r <= '0;
      err_r <= 1'b0;
    end else if (ctl_we) begin
      ctl_r <= wr_ctl;
      err_r <= new_illegal;
    end
  end

  assign ctl_q   = ctl_r;
  assign cfg_err = err_r;

  // R5: the flag only moves on a control write
  p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(cfg_err));

  // R5: a reserved mode written always raises the flag
  p_rsvd_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[1:0] == 2'b11) |=> cfg_err);

endmodule

// File: rtl/dmau_addr_step.sv
module dmau_addr_step
  import dmau_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              xfer_done,
  input  logic              cfg_err,
  input  dmode_e            dmode,
  input  size_e             size,
  input  logic              single,
  input  logic              to_dev,
  output logic [ADDR_W-1:0] dst_addr
);

  logic [ADDR_W-1:0] addr_r;
  logic [ADDR_W-1:0] addr_nxt;
  logic [ADDR_W-1:0] delta;
  logic              dst_frozen;
  logic              step_fire;

  assign delta      = ADDR_W'(beat_bytes(size));
  assign dst_frozen = single & to_dev;
  assign step_fire  = xfer_done & ~cfg_err & ~dst_frozen;

  always_comb begin
    case (dmode)
      DM_INC:  addr_nxt = addr_r + delta;
      DM_DEC:  addr_nxt = addr_r - delta;
      default: addr_nxt = addr_r;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         addr_r <= '0;
    else if (addr_we)   addr_r <= addr_wdata;
    else if (step_fire) addr_r <= addr_nxt;
  end

  assign dst_addr = addr_r;

  // R6: a flagged configuration never moves the address
  p_err_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !addr_we) |=> $stable(dst_addr));

  // R10: single mode towards the device keeps the address
  p_dev_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (single && to_dev && !addr_we) |=> $stable(dst_addr));

  // R4: fixed mode keeps the address
  p_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dmode == DM_FIXED && !addr_we) |=> $stable(dst_addr));

  // R13: a load wins over a beat
  p_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
    addr_we |=> dst_addr == $past(addr_wdata));

endmodule

// File: rtl/dmau_ack_gen.sv
module dmau_ack_gen
  import dmau_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_cyc,
  input  logic wr_cyc,
  input  logic single,
  input  logic ack_wr,
  input  logic ack_pol,
  input  logic cfg_err,
  output logic dack
);

  logic ack_fire;
  logic dack_r;

  assign ack_fire = ~cfg_err & ack_wanted(single, ack_wr, rd_cyc, wr_cyc);

  always_ff @(posedge clk) begin
    if (!rst_n) dack_r <= 1'b1;
    else        dack_r <= ack_pol ? ack_fire : ~ack_fire;
  end

  assign dack = dack_r;

  // R9: no strobe means the inactive level next cycle
  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_cyc && !wr_cyc) |=> dack == !$past(ack_pol));

  // R6: no acknowledge under a flagged configuration
  p_err_no_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> dack == !$past(ack_pol));

  // R7: dual mode with read phase ignores a lone write strobe
  p_dual_rd_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!single && !ack_wr && !rd_cyc) |=> dack == !$past(ack_pol));

endmodule

// File: rtl/dma_dst_ack_unit.sv
module dma_dst_ack_unit
  import dmau_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              addr_we,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic              rd_cyc,
  input  logic              wr_cyc,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              dack,
  output logic              cfg_err
);

  ctl_t ctl_q;
  logic err_q;

  dmau_ctl_regs #(.CHAN_ID(CHAN_ID)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_q     (ctl_q),
    .cfg_err   (err_q)
  );

  dmau_addr_step #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_we    (addr_we),
    .addr_wdata (addr_wdata),
    .xfer_done  (xfer_done),
    .cfg_err    (err_q),
    .dmode      (ctl_q.dmode),
    .size       (ctl_q.size),
    .single     (ctl_q.single),
    .to_dev     (ctl_q.to_dev),
    .dst_addr   (dst_addr)
  );

  dmau_ack_gen u_ack (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_cyc  (rd_cyc),
    .wr_cyc  (wr_cyc),
    .single  (ctl_q.single),
    .ack_wr  (ctl_q.ack_wr),
    .ack_pol (ctl_q.ack_pol),
    .cfg_err (err_q),
    .dack    (dack)
  );

  assign ctl_rdata = ctl_q;
  assign cfg_err   = err_q;

  // R11: reduced channels never hold acknowledge controls
  p_no_ack_bits_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (CHAN_ID >= 2) |-> ctl_rdata[5:4] == 2'b00);

endmodule

// File: tb/sim_dma_dst_ack_unit.sv
`timescale 1ns/1ps
module sim_dma_dst_ack_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        addr_we = 1'b0;
  logic [31:0] addr_wdata = '0;
  logic        rd_cyc = 1'b0;
  logic        wr_cyc = 1'b0;
  logic        xfer_done = 1'b0;
  logic [7:0]  rdata0, rdata1;
  logic [31:0] addr0, addr1;
  logic        dack0, dack1, err0, err1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dma_dst_ack_unit #(.ADDR_W(32), .CHAN_ID(0)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(rdata0), .addr_we(addr_we), .addr_wdata(addr_wdata),
    .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .xfer_done(xfer_done),
    .dst_addr(addr0), .dack(dack0), .cfg_err(err0));

  dma_dst_ack_unit #(.ADDR_W(32), .CHAN_ID(2)) u1 (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(rdata1), .addr_we(addr_we), .addr_wdata(addr_wdata),
    .rd_cyc(rd_cyc), .wr_cyc(wr_cyc), .xfer_done(xfer_done),
    .dst_addr(addr1), .dack(dack1), .cfg_err(err1));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cbyte(bit dev, bit sgl, bit pol, bit awr,
                                       logic [1:0] sz, logic [1:0] md);
    return {dev, sgl, pol, awr, sz, md};
  endfunction

  function automatic logic [31:0] sz_bytes(logic [1:0] sz);
    return (sz == 2'd3) ? 32'd16 : (32'd1 << sz);
  endfunction

  task automatic put_ctl(logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic put_addr(logic [31:0] v);
    @(negedge clk); addr_we = 1'b1; addr_wdata = v;
    @(negedge clk); addr_we = 1'b0;
  endtask

  // One-cycle strobe; returns at the next falling edge, after the sampling edge.
  task automatic beat(bit rd, bit wr, bit dn);
    @(negedge clk); rd_cyc = rd; wr_cyc = wr; xfer_done = dn;
    @(negedge clk); rd_cyc = 1'b0; wr_cyc = 1'b0; xfer_done = 1'b0;
  endtask

  task automatic t_reset_r1;
    chk("R1 ctl readback", {24'd0, rdata0}, 32'd0);
    chk("R1 address", addr0, 32'd0);
    chk("R1 err", {31'd0, err0}, 32'd0);
    chk("R1 dack idle", {31'd0, dack0}, 32'd1);
  endtask

  task automatic t_increment_r2;
    logic [31:0] exp = 32'h100;
    put_addr(32'h100);
    for (int s = 0; s < 4; s++) begin
      put_ctl(cbyte(0, 0, 0, 0, 2'(s), 2'b01));
      beat(1'b0, 1'b1, 1'b1);
      exp = exp + sz_bytes(2'(s));
      chk("R2 increment step", addr0, exp);
    end
  endtask

  task automatic t_decrement_r3;
    logic [31:0] exp = addr0;
    for (int s = 0; s < 3; s++) begin
      put_ctl(cbyte(0, 0, 0, 0, 2'(s), 2'b10));
      beat(1'b0, 1'b1, 1'b1);
      exp = exp - sz_bytes(2'(s));
      chk("R3 decrement step", addr0, exp);
    end
  endtask

  task automatic t_fixed_r4;
    logic [31:0] keep = addr0;
    put_ctl(cbyte(0, 0, 0, 0, 2'b10, 2'b00));
    beat(1'b0, 1'b1, 1'b1);
    beat(1'b0, 1'b1, 1'b1);
    chk("R4 fixed address", addr0, keep);
  endtask

  task automatic t_illegal_r5_r6;
    logic [31:0] keep;
    put_ctl(cbyte(0, 0, 1, 0, 2'b00, 2'b11));
    chk("R5 reserved mode flag", {31'd0, err0}, 32'd1);
    put_ctl(cbyte(0, 0, 1, 0, 2'b11, 2'b00));
    chk("R5 burst fixed flag", {31'd0, err0}, 32'd1);
    put_ctl(cbyte(0, 0, 1, 0, 2'b11, 2'b10));
    chk("R5 burst decrement flag", {31'd0, err0}, 32'd1);
    keep = addr0;
    beat(1'b1, 1'b0, 1'b1);
    chk("R6 no ack under error", {31'd0, dack0}, 32'd0);
    chk("R6 no step under error", addr0, keep);
    put_ctl(cbyte(0, 0, 1, 0, 2'b11, 2'b01));
    chk("R5 legal write clears", {31'd0, err0}, 32'd0);
  endtask

  task automatic t_dual_phase_r7_r9;
    put_ctl(cbyte(0, 0, 1, 0, 2'b00, 2'b00));
    beat(1'b1, 1'b0, 1'b0);
    chk("R7 read phase ack", {31'd0, dack0}, 32'd1);
    @(negedge clk);
    chk("R9 high-active idle", {31'd0, dack0}, 32'd0);
    beat(1'b0, 1'b1, 1'b0);
    chk("R7 write strobe ignored", {31'd0, dack0}, 32'd0);
    put_ctl(cbyte(0, 0, 1, 1, 2'b00, 2'b00));
    beat(1'b0, 1'b1, 1'b0);
    chk("R7 write phase ack", {31'd0, dack0}, 32'd1);
    beat(1'b1, 1'b0, 1'b0);
    chk("R7 read strobe ignored", {31'd0, dack0}, 32'd0);
  endtask

  task automatic t_single_r8_r9;
    put_ctl(cbyte(0, 1, 0, 0, 2'b00, 2'b00));
    beat(1'b0, 1'b1, 1'b0);
    chk("R8 single ack on write, low active", {31'd0, dack0}, 32'd0);
    @(negedge clk);
    chk("R9 low-active idle", {31'd0, dack0}, 32'd1);
    put_ctl(cbyte(0, 1, 1, 1, 2'b00, 2'b00));
    beat(1'b1, 1'b0, 1'b0);
    chk("R8 single ack on read", {31'd0, dack0}, 32'd1);
  endtask

  task automatic t_single_dev_r10;
    logic [31:0] keep;
    put_addr(32'h2000);
    put_ctl(cbyte(1, 1, 0, 0, 2'b10, 2'b01));
    keep = addr0;
    beat(1'b0, 1'b1, 1'b1);
    chk("R10 to-device address held", addr0, keep);
    put_ctl(cbyte(0, 1, 0, 0, 2'b10, 2'b01));
    beat(1'b1, 1'b0, 1'b1);
    chk("R10 from-device address steps", addr0, keep + 32'd4);
  endtask

  task automatic t_reduced_r11;
    put_ctl(cbyte(0, 0, 1, 1, 2'b00, 2'b00));
    chk("R11 ack bits read zero", {24'd0, rdata1}, 32'h00);
    beat(1'b1, 1'b0, 1'b0);
    chk("R11 read-phase active-low ack", {31'd0, dack1}, 32'd0);
    beat(1'b0, 1'b1, 1'b0);
    chk("R11 write strobe no ack", {31'd0, dack1}, 32'd1);
  endtask

  task automatic t_wrap_r12;
    put_addr(32'hFFFF_FFFE);
    put_ctl(cbyte(0, 0, 0, 0, 2'b10, 2'b01));
    beat(1'b0, 1'b1, 1'b1);
    chk("R12 increment wraps", addr0, 32'h0000_0002);
    put_addr(32'h0);
    put_ctl(cbyte(0, 0, 0, 0, 2'b00, 2'b10));
    beat(1'b0, 1'b1, 1'b1);
    chk("R12 decrement wraps", addr0, 32'hFFFF_FFFF);
  endtask

  task automatic t_load_priority_r13;
    put_ctl(cbyte(0, 0, 0, 0, 2'b10, 2'b01));
    @(negedge clk); addr_we = 1'b1; addr_wdata = 32'h0000_5000; xfer_done = 1'b1;
    @(negedge clk); addr_we = 1'b0; xfer_done = 1'b0;
    chk("R13 load beats step", addr0, 32'h0000_5000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_increment_r2();
    t_decrement_r3();
    t_fixed_r4();
    t_illegal_r5_r6();
    t_dual_phase_r7_r9();
    t_single_r8_r9();
    t_single_dev_r10();
    t_reduced_r11();
    t_wrap_r12();
    t_load_priority_r13();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule